// File: doc/BRIEF.md
# Sequential Shift-and-Add Multiplier

This block multiplies two operands over several clock cycles. It adds at most one partial product per cycle into an accumulator. The accumulator and the multiplier register form one joint register that shifts right by one bit after every add. A request is accepted only while the block is idle. The block latches both operands and the mode, then runs for exactly `WIDTH` step cycles. When it finishes, it raises a one-cycle completion flag. The full double-width product stays on the output until the next request is accepted.

One adder/subtractor, one bit wider than the operands, handles both unsigned and two's-complement operands. In signed mode the partial product taken on the last step is subtracted, because the multiplier's top bit has negative weight. Every shift also copies the true sign of the widened sum into the top of the accumulator. In unsigned mode the carry-out fills that position.

Top module: `seq_mul`

## Requirements
- R1: While `rst_ni` is low, and after its release until the first accepted request, `busy_o`, `done_o` and `product_o` are all zero.
- R2: A request (`start_i` high while `busy_o` is low) is accepted on that clock edge. `busy_o` is high from the next cycle on, and `done_o` is first seen high after the (`WIDTH`+1)-th rising edge counted from the accepting edge. `busy_o` is low whenever `done_o` is high.
- R3: With `signed_i` = 0 at acceptance, `product_o` at `done_o` equals the unsigned product of the two operands (2·`WIDTH` bits).
- R4: With `signed_i` = 1 at acceptance, both operands are read as two's complement, and `product_o` at `done_o` is the two's-complement product in 2·`WIDTH` bits.
- R5: In signed mode the product is exact when either operand is the most negative value. This includes most negative times most negative, which gives 2^(2·`WIDTH`−2). In unsigned mode all-ones times all-ones is exact.
- R6: `done_o` stays high for exactly one cycle per accepted request.
- R7: While idle and no request is presented, `product_o` does not change.
- R8: A `start_i` pulse while `busy_o` is high is ignored. The running result and its timing are unchanged.
- R9: `signed_i` and the operand inputs are sampled only at acceptance. Changing them during a run has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a multiplication (accepted only when idle) |
| signed_i | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| multiplicand_i | input | WIDTH | Multiplicand |
| multiplier_i | input | WIDTH | Multiplier |
| busy_o | output | 1 | Multiplication in progress |
| done_o | output | 1 | One-cycle flag: product valid |
| product_o | output | 2*WIDTH | Product, held until the next accepted request |

## Verification
The assertions assume that `start_i` is driven to a known level after reset. They also assume that operands and mode presented with an accepted request are known values, because the checker latches them at that edge as the reference. The stimulus changes inputs only at falling edges and always presents defined operands. Its deliberate mid-run pokes of `start_i`, `signed_i` and the operands happen only while `busy_o` is high, where the design is required to ignore them.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mul_state_e;
endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl #(
  parameter int unsigned WIDTH = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic last_o,
  output logic busy_o,
  output logic done_o
);
  import mul_pkg::*;

  localparam int unsigned CW = $clog2(WIDTH) + 1;
  localparam logic [CW-1:0] LAST_STEP = CW'(WIDTH - 1);

  mul_state_e state_q;
  logic [CW-1:0] cnt_q;
  logic done_q;

  assign busy_o = (state_q == ST_RUN);
  assign load_o = start_i && (state_q == ST_IDLE);
  assign step_o = busy_o;
  assign last_o = busy_o && (cnt_q == LAST_STEP);
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (load_o) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
          end
        end
        ST_RUN: begin
          if (last_o) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mul_addsub.sv
module mul_addsub #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] acc_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  logic             use_i,
  input  logic             sub_i,
  input  logic             sgn_i,
  output logic [WIDTH:0]   sum_o
);
  logic [WIDTH:0] acc_x, opd_x;

  // widen by one bit: sign in signed mode, zero otherwise
  assign acc_x = {sgn_i & acc_i[WIDTH-1], acc_i};
  assign opd_x = use_i ? {sgn_i & mcand_i[WIDTH-1], mcand_i} : '0;
  assign sum_o = sub_i ? (acc_x - opd_x) : (acc_x + opd_x);
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath #(
  parameter int unsigned WIDTH = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               step_i,
  input  logic               last_i,
  input  logic               signed_i,
  input  logic [WIDTH-1:0]   multiplicand_i,
  input  logic [WIDTH-1:0]   multiplier_i,
  output logic [2*WIDTH-1:0] product_o
);
  logic [WIDTH-1:0] mcand_q, acc_q, mplr_q;
  logic             sgn_q;
  logic [WIDTH:0]   sum;

  mul_addsub #(.WIDTH(WIDTH)) u_addsub (
    .acc_i   (acc_q),
    .mcand_i (mcand_q),
    .use_i   (mplr_q[0]),
    .sub_i   (last_i & sgn_q),
    .sgn_i   (sgn_q),
    .sum_o   (sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q <= '0;
      acc_q   <= '0;
      mplr_q  <= '0;
      sgn_q   <= 1'b0;
    end else if (load_i) begin
      mcand_q <= multiplicand_i;
      acc_q   <= '0;
      mplr_q  <= multiplier_i;
      sgn_q   <= signed_i;
    end else if (step_i) begin
      // {acc,mplr} shifts right; widened sum supplies the new top bit
      acc_q  <= sum[WIDTH:1];
      mplr_q <= {sum[0], mplr_q[WIDTH-1:1]};
    end
  end

  assign product_o = {acc_q, mplr_q};
endmodule

// File: rtl/seq_mul.sv
module seq_mul #(
  parameter int unsigned WIDTH = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               signed_i,
  input  logic [WIDTH-1:0]   multiplicand_i,
  input  logic [WIDTH-1:0]   multiplier_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [2*WIDTH-1:0] product_o
);
  logic load, step, last;

  mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .load_o  (load),
    .step_o  (step),
    .last_o  (last),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  mul_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .load_i         (load),
    .step_i         (step),
    .last_i         (last),
    .signed_i       (signed_i),
    .multiplicand_i (multiplicand_i),
    .multiplier_i   (multiplier_i),
    .product_o      (product_o)
  );
endmodule

// File: rtl/mul_chk.sv
module mul_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               signed_i,
  input logic [WIDTH-1:0]   multiplicand_i,
  input logic [WIDTH-1:0]   multiplier_i,
  input logic               busy_o,
  input logic               done_o,
  input logic [2*WIDTH-1:0] product_o
);
  localparam int unsigned CW = $clog2(WIDTH + 2) + 1;
  localparam int unsigned PW = 2 * WIDTH;

  logic [CW-1:0] cyc_q;
  logic [PW-1:0] exp_q;
  logic [PW-1:0] ext_a, ext_b;

  assign ext_a = signed_i ? {{WIDTH{multiplicand_i[WIDTH-1]}}, multiplicand_i}
                          : {{WIDTH{1'b0}}, multiplicand_i};
  assign ext_b = signed_i ? {{WIDTH{multiplier_i[WIDTH-1]}}, multiplier_i}
                          : {{WIDTH{1'b0}}, multiplier_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
      exp_q <= '0;
    end else if (start_i && !busy_o) begin
      cyc_q <= CW'(1);
      exp_q <= PW'(ext_a * ext_b);
    end else if (busy_o) begin
      cyc_q <= cyc_q + 1'b1;
    end
  end

  // R2
  a_r2_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cyc_q == CW'(WIDTH + 1)));
  a_r2_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r2_busy_until_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || done_o));
  // R3, R4, R8, R9: result matches operands latched at acceptance
  a_r4_product: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (product_o == exp_q));
  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(product_o));
endmodule

bind seq_mul mul_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .start_i        (start_i),
  .signed_i       (signed_i),
  .multiplicand_i (multiplicand_i),
  .multiplier_i   (multiplier_i),
  .busy_o         (busy_o),
  .done_o         (done_o),
  .product_o      (product_o)
);

// File: tb/sim_seq_mul.sv
`timescale 1ns/1ps
module sim_seq_mul;
  localparam int unsigned W  = 8;
  localparam int unsigned PW = 2 * W;

  typedef struct {
    logic [PW-1:0] prod;
    int            edge0;
    string         tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          sgn = 1'b0;
  logic [W-1:0]  mcand = '0;
  logic [W-1:0]  mplr = '0;
  logic          busy, done;
  logic [PW-1:0] prod;

  int     n_chk = 0;
  int     n_bad = 0;
  int     edge_cnt = 0;
  item_t  sb[$];
  logic   prev_done = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  seq_mul #(.WIDTH(W)) u0 (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .start_i        (start),
    .signed_i       (sgn),
    .multiplicand_i (mcand),
    .multiplier_i   (mplr),
    .busy_o         (busy),
    .done_o         (done),
    .product_o      (prod)
  );

  function automatic logic [PW-1:0] exp_prod(logic [W-1:0] a, logic [W-1:0] b, logic s);
    logic [PW-1:0] xa, xb;
    xa = s ? {{W{a[W-1]}}, a} : {{W{1'b0}}, a};
    xb = s ? {{W{b[W-1]}}, b} : {{W{1'b0}}, b};
    return PW'(xa * xb);
  endfunction

  task automatic check(string tag, logic [PW-1:0] act, logic [PW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops scoreboard on completion
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done) check("R6 done one cycle", PW'(done), PW'(0));
      if (done) begin
        if (sb.size() == 0) begin
          check("R2 unexpected done", PW'(1), PW'(0));
        end else begin
          item_t it;
          it = sb.pop_front();
          check(it.tag, prod, it.prod);
          check("R2 latency", PW'(edge_cnt - it.edge0), PW'(W + 1));
          check("R2 not busy at done", PW'(busy), PW'(0));
        end
      end
      prev_done = done;
    end
  end

  // driver: poke = restart attempt while busy (R8), flip = change mode/operands mid-run (R9)
  task automatic run_op(logic [W-1:0] a, logic [W-1:0] b, logic s, string tag,
                        bit poke = 0, bit flip = 0);
    item_t it;
    logic [PW-1:0] e;
    @(negedge clk);
    mcand = a; mplr = b; sgn = s; start = 1'b1;
    e = exp_prod(a, b, s);
    it.prod = e; it.edge0 = edge_cnt; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after accept", PW'(busy), PW'(1));
    if (flip) begin
      sgn = ~s; mcand = ~a; mplr = b ^ 8'h5A;
    end
    if (poke) begin
      @(negedge clk);
      @(negedge clk);
      mcand = a + 8'd3; mplr = b + 8'd7; sgn = ~s; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    // R7: hold while idle
    repeat (3) begin
      @(negedge clk);
      check("R7 product held", prod, e);
    end
  endtask

  initial begin
    #40000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset product", prod, '0);
    check("R1 reset busy", PW'(busy), PW'(0));
    check("R1 reset done", PW'(done), PW'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after release", {prod[PW-1:2], busy, done}, '0);

    run_op(8'd3,   8'd5,   1'b0, "R3 unsigned small");
    run_op(8'd0,   8'd200, 1'b0, "R3 unsigned zero");
    run_op(8'd255, 8'd255, 1'b0, "R5 unsigned all-ones");
    run_op(8'd128, 8'd128, 1'b0, "R3 unsigned top bit");
    run_op(8'hFA,  8'd7,   1'b1, "R4 signed neg*pos");
    run_op(8'd9,   8'hF3,  1'b1, "R4 signed pos*neg");
    run_op(8'hFF,  8'hFF,  1'b1, "R4 signed -1*-1");
    run_op(8'h80,  8'h80,  1'b1, "R5 signed min*min");
    run_op(8'h80,  8'h7F,  1'b1, "R5 signed min*max");
    run_op(8'h7F,  8'h80,  1'b1, "R5 signed max*min");
    run_op(8'h80,  8'hFF,  1'b1, "R5 signed min*-1");
    run_op(8'd77,  8'd13,  1'b0, "R8 restart ignored unsigned", 1, 0);
    run_op(8'hC1,  8'h22,  1'b1, "R8 restart ignored signed", 1, 0);
    run_op(8'hB5,  8'h93,  1'b0, "R9 inputs changed mid-run", 0, 1);
    run_op(8'hB5,  8'h93,  1'b1, "R9 mode changed mid-run", 0, 1);
    for (int i = 0; i < 40; i++)
      run_op(W'($urandom), W'($urandom), 1'b0, "R3 unsigned random");
    for (int i = 0; i < 40; i++)
      run_op(W'($urandom), W'($urandom), 1'b1, "R4 signed random");

    repeat (2) @(negedge clk);
    check("R2 scoreboard drained", PW'(sb.size()), PW'(0));
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule